// File: doc/BRIEF.md
# Video Decimator and Line Packetizer

This block takes one channel of 4:2:2 digital video in which every clock carries a 16-bit word: a luma byte and a chroma byte. Line and frame timing is not carried on separate wires. It is embedded in the stream as a four-word timing code. The block finds the active picture from those codes and halves it in both directions. It then sends the remaining samples out as a stream with a valid/ready handshake. A 1920x1080 source becomes a 960x540 stream. That lower rate is what lets a downstream memory writer keep up with several channels at once. A system with four camera inputs places four copies side by side, one per channel, and each copy runs on its own.

Each output line ends with a last-beat marker on its final sample. The first sample of a frame carries a start-of-frame marker. A running output-line count is available at the ports, and a one-cycle strobe fires once a full frame of lines has gone out. The video input cannot be paused. Complete decimated lines are therefore held in two line banks until the consumer takes them. A line that finds no free bank is dropped, and an overflow flag is raised. An active line whose length is wrong is also dropped, and it raises a sticky length-error flag.

Top module: `vdec_packetizer`

## Requirements
- R1: A timing code is four consecutive words whose luma bytes are all-ones, zero, zero, then a code byte. In the code byte, bit 7 is 1, bit 6 is the field bit F, bit 5 is the blanking bit V, and bit 4 is H (H=0 marks start of active video, H=1 marks end of active video). Only the words between a code with V=0,H=0 and the next code with H=1 are active. Words in horizontal or vertical blanking never produce output.
- R2: Within an active line, the input word at index i (counted from 0 after the start code) is kept only when i mod 4 is 0 or 1. Output sample k of a line is input word 4*(k/2)+(k mod 2). The kept word is forwarded unchanged, with luma in bits 15:8 and chroma in bits 7:0.
- R3: Active lines are numbered from 0 at each start of frame. Only even-numbered lines below ACT_H are output.
- R4: Every output line is exactly ACT_W/2 beats long. m_tlast is high on the beat at position ACT_W/2-1 and on no other beat.
- R5: A start of frame is the first start-of-active code after a code with V=1, or after a change of F. m_tuser is high on the first beat of the first line sent after it, and on no other beat.
- R6: out_lines holds the number of lines finished in the current frame and returns to 0 at each start of frame. frame_done is a one-cycle pulse in the cycle after the last beat of line ACT_H/2 of a frame is accepted. At that point out_lines wraps to 0.
- R7: While m_tready is low, m_tvalid stays high and m_tdata, m_tlast and m_tuser hold their values. Under intermittent backpressure, no sample is lost or repeated while a bank is free.
- R8: Two line banks hold finished lines. A kept line that starts while the next bank is still waiting to be read is dropped entirely, and the sticky overflow output goes high until reset.
- R9: An active line with a word count other than ACT_W between its two codes is dropped entirely, even if it would otherwise be kept. The sticky len_err output goes high until reset. A wrong-length line that is not kept also sets len_err.
- R10: After reset, m_tvalid, frame_done, overflow, len_err and out_lines are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock, one word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| vid_word | input | 2*CW | Video word: luma in the upper byte, chroma in the lower byte |
| m_tdata | output | 2*CW | Output sample (a luma/chroma word pair member) |
| m_tvalid | output | 1 | Output sample is valid |
| m_tready | input | 1 | Consumer accepts the sample |
| m_tlast | output | 1 | Final sample of an output line |
| m_tuser | output | 1 | First sample of an output frame |
| frame_done | output | 1 | One-cycle pulse after the frame's final line |
| out_lines | output | $clog2(ACT_H/2+1) | Lines finished in the current frame |
| overflow | output | 1 | Sticky: a kept line was dropped for lack of a bank |
| len_err | output | 1 | Sticky: an active line had the wrong length |

## Verification
The bench uses a small frame of 8x6 active words. Each pixel value encodes its line, its position and the frame number, so a beat taken from the wrong column, row or frame shows up in the data compare. Frames are sent with the consumer always ready, with a pseudo-random ready pattern, and with ready held low for a whole frame. These three runs separate correct decimation from lost or repeated samples under backpressure and from the bank-overflow drop. Further frames contain a short kept line and a long unkept line. These show that wrong-length lines are dropped and flagged, and that the frame counter restarts at each start of frame.

// File: rtl/vdp_pkg.sv
package vdp_pkg;

    // Number of whole-line holding banks between the writer and reader
    localparam int NBANKS = 2;

    // Decoded timing-code event, valid in the cycle of the code byte
    typedef struct packed {
        logic hit;   // a full timing code ends on this word
        logic f;     // field bit
        logic v;     // vertical blanking bit
        logic h;     // 1: end of active video, 0: start of active video
    } trs_evt_t;

    // Build the event from the code byte of a timing code
    function automatic trs_evt_t decode_code(input logic hit, input logic [2:0] fvh);
        trs_evt_t e;
        e.hit = hit;
        e.f   = fvh[2];
        e.v   = fvh[1];
        e.h   = fvh[0];
        return e;
    endfunction

    // Word pairs are kept on alternate pairs: indices 0,1 kept, 2,3 dropped
    function automatic logic keep_pair(input logic idx_bit1);
        return !idx_bit1;
    endfunction

endpackage

// File: rtl/vdp_trs_parser.sv
module vdp_trs_parser
    import vdp_pkg::*;
#(
    parameter int CW = 8
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] luma,
    output trs_evt_t      evt
);

    logic [CW-1:0] hist1, hist2, hist3;
    logic          seq_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist1 <= '0;
            hist2 <= '0;
            hist3 <= '0;
        end else begin
            hist1 <= luma;
            hist2 <= hist1;
            hist3 <= hist2;
        end
    end

    // all-ones, zero, zero, then a code byte with its top bit set
    assign seq_hit = (hist3 == '1) && (hist2 == '0) && (hist1 == '0) && luma[CW-1];
    assign evt     = decode_code(seq_hit, luma[CW-2:CW-4]);

endmodule

// File: rtl/vdp_line_writer.sv
module vdp_line_writer
    import vdp_pkg::*;
#(
    parameter  int CW    = 8,
    parameter  int ACT_W = 1920,
    parameter  int ACT_H = 1080,
    localparam int DW    = 2 * CW,
    localparam int OUT_W = ACT_W / 2,
    localparam int AW    = $clog2(OUT_W),
    localparam int IW    = $clog2(ACT_W + 8),
    localparam int LW    = $clog2(ACT_H + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     din,
    input  trs_evt_t          evt,
    input  logic              rd_done,
    input  logic              rd_bank,
    output logic              wr_en,
    output logic              wr_bank,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [NBANKS-1:0] bank_full,
    output logic [NBANKS-1:0] bank_sof,
    output logic              overflow,
    output logic              len_err
);

    localparam logic [IW-1:0] IDX_LIMIT = IW'(ACT_W);
    localparam logic [IW-1:0] IDX_AT_END = IW'(ACT_W + 3); // three preamble words precede the end code
    localparam logic [IW-1:0] IDX_SAT   = '1;
    localparam logic [LW-1:0] LINE_LIMIT = LW'(ACT_H);

    logic          in_act;
    logic          line_keep;
    logic [IW-1:0] idx;
    logic [LW-1:0] act_line;
    logic          vb_seen;
    logic          last_f;
    logic          sof_pend;

    logic          sav_act, eav_any, frame_start, keep_now, bank_free, len_ok;
    logic [LW-1:0] line_now;

    always_comb begin
        sav_act     = evt.hit && !evt.h && !evt.v;
        eav_any     = evt.hit && evt.h;
        frame_start = sav_act && (vb_seen || (evt.f != last_f));
        line_now    = frame_start ? '0 : act_line;
        keep_now    = !line_now[0] && (line_now < LINE_LIMIT);
        bank_free   = !bank_full[wr_bank];
        len_ok      = (idx == IDX_AT_END);
    end

    assign wr_en   = in_act && line_keep && !evt.hit && (idx < IDX_LIMIT) && keep_pair(idx[1]);
    assign wr_addr = AW'({idx[IW-1:2], idx[0]});
    assign wr_data = din;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_act    <= 1'b0;
            line_keep <= 1'b0;
            idx       <= '0;
            act_line  <= '0;
            vb_seen   <= 1'b0;
            last_f    <= 1'b0;
            sof_pend  <= 1'b0;
            wr_bank   <= 1'b0;
            bank_full <= '0;
            bank_sof  <= '0;
            overflow  <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            if (in_act && idx != IDX_SAT) begin
                idx <= idx + 1'b1;
            end
            if (rd_done) begin
                bank_full[rd_bank] <= 1'b0;
            end
            if (evt.hit && evt.v) begin
                vb_seen <= 1'b1;
            end
            if (sav_act) begin
                in_act    <= 1'b1;
                idx       <= '0;
                line_keep <= keep_now && bank_free;
                last_f    <= evt.f;
                if (in_act) begin
                    len_err <= 1'b1;      // previous line never saw its end code
                end
                if (keep_now && !bank_free) begin
                    overflow <= 1'b1;
                end
                if (frame_start) begin
                    act_line <= '0;
                    sof_pend <= 1'b1;
                    vb_seen  <= 1'b0;
                end
            end else if (eav_any && in_act) begin
                in_act    <= 1'b0;
                line_keep <= 1'b0;
                if (act_line != LINE_LIMIT) begin
                    act_line <= act_line + 1'b1;
                end
                if (!len_ok) begin
                    len_err <= 1'b1;
                end
                if (line_keep && len_ok) begin
                    bank_full[wr_bank] <= 1'b1;
                    bank_sof[wr_bank]  <= sof_pend;
                    sof_pend           <= 1'b0;
                    wr_bank            <= ~wr_bank;
                end
            end
        end
    end

endmodule

// File: rtl/vdp_line_banks.sv
module vdp_line_banks
    import vdp_pkg::*;
#(
    parameter  int DW    = 16,
    parameter  int DEPTH = 960,
    localparam int AW    = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] bank_q [NBANKS];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [DW-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                store[wr_addr] <= wr_data;
            end
        end

        assign bank_q[b] = store[rd_addr];
    end

    assign rd_data = bank_q[rd_bank];

endmodule

// File: rtl/vdp_stream_reader.sv
module vdp_stream_reader
    import vdp_pkg::*;
#(
    parameter  int DW    = 16,
    parameter  int OUT_W = 960,
    parameter  int OUT_H = 540,
    localparam int AW    = $clog2(OUT_W),
    localparam int LW    = $clog2(OUT_H + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [NBANKS-1:0] bank_full,
    input  logic [NBANKS-1:0] bank_sof,
    input  logic [DW-1:0]     rd_data,
    output logic              rd_bank,
    output logic [AW-1:0]     rd_addr,
    output logic              rd_done,
    output logic [DW-1:0]     m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    output logic              m_tuser,
    output logic              frame_done,
    output logic [LW-1:0]     out_lines
);

    localparam logic [AW-1:0] ADDR_LAST = AW'(OUT_W - 1);
    localparam logic [LW-1:0] LINE_LAST = LW'(OUT_H - 1);

    logic busy;
    logic cur_sof;

    assign m_tvalid = busy;
    assign m_tdata  = rd_data;
    assign m_tlast  = busy && (rd_addr == ADDR_LAST);
    assign m_tuser  = busy && cur_sof && (rd_addr == '0);
    assign rd_done  = busy && m_tready && (rd_addr == ADDR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cur_sof    <= 1'b0;
            rd_bank    <= 1'b0;
            rd_addr    <= '0;
            out_lines  <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!busy) begin
                if (bank_full[rd_bank]) begin
                    busy    <= 1'b1;
                    rd_addr <= '0;
                    cur_sof <= bank_sof[rd_bank];
                    if (bank_sof[rd_bank]) begin
                        out_lines <= '0;
                    end
                end
            end else if (m_tready) begin
                if (rd_addr == ADDR_LAST) begin
                    busy    <= 1'b0;
                    rd_bank <= ~rd_bank;
                    if (out_lines == LINE_LAST) begin
                        out_lines  <= '0;
                        frame_done <= 1'b1;
                    end else begin
                        out_lines <= out_lines + 1'b1;
                    end
                end else begin
                    rd_addr <= rd_addr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vdec_packetizer.sv
module vdec_packetizer
    import vdp_pkg::*;
#(
    parameter  int CW    = 8,
    parameter  int ACT_W = 1920,
    parameter  int ACT_H = 1080,
    localparam int DW    = 2 * CW,
    localparam int OUT_W = ACT_W / 2,
    localparam int OUT_H = ACT_H / 2,
    localparam int AW    = $clog2(OUT_W),
    localparam int OLW   = $clog2(OUT_H + 1)
)(
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  vid_word,
    output logic [DW-1:0]  m_tdata,
    output logic           m_tvalid,
    input  logic           m_tready,
    output logic           m_tlast,
    output logic           m_tuser,
    output logic           frame_done,
    output logic [OLW-1:0] out_lines,
    output logic           overflow,
    output logic           len_err
);

    trs_evt_t          evt;
    logic              wr_en, wr_bank, rd_bank, rd_done;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [DW-1:0]     wr_data, rd_data;
    logic [NBANKS-1:0] bank_full, bank_sof;

    vdp_trs_parser #(.CW(CW)) parser_i (
        .clk  (clk),
        .rst  (rst),
        .luma (vid_word[DW-1:CW]),
        .evt  (evt)
    );

    vdp_line_writer #(.CW(CW), .ACT_W(ACT_W), .ACT_H(ACT_H)) writer_i (
        .clk       (clk),
        .rst       (rst),
        .din       (vid_word),
        .evt       (evt),
        .rd_done   (rd_done),
        .rd_bank   (rd_bank),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .bank_full (bank_full),
        .bank_sof  (bank_sof),
        .overflow  (overflow),
        .len_err   (len_err)
    );

    vdp_line_banks #(.DW(DW), .DEPTH(OUT_W)) banks_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    vdp_stream_reader #(.DW(DW), .OUT_W(OUT_W), .OUT_H(OUT_H)) reader_i (
        .clk        (clk),
        .rst        (rst),
        .bank_full  (bank_full),
        .bank_sof   (bank_sof),
        .rd_data    (rd_data),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .rd_done    (rd_done),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tlast    (m_tlast),
        .m_tuser    (m_tuser),
        .frame_done (frame_done),
        .out_lines  (out_lines)
    );

endmodule

// File: rtl/vdec_packetizer_chk.sv
module vdec_packetizer_chk #(
    parameter  int DW    = 16,
    parameter  int OUT_W = 960,
    localparam int BW    = $clog2(OUT_W) + 1
)(
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] m_tdata,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic          m_tlast,
    input logic          m_tuser,
    input logic          frame_done,
    input logic          overflow,
    input logic          len_err
);

    localparam logic [BW-1:0] BEAT_LAST = BW'(OUT_W - 1);

    // independent beat position within the current output line
    logic [BW-1:0] beat_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_pos <= '0;
        end else if (m_tvalid && m_tready) begin
            beat_pos <= m_tlast ? '0 : beat_pos + 1'b1;
        end
    end

    assert_tlast_position_R4: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tlast) |-> (beat_pos == BEAT_LAST));

    assert_tlast_not_missed_R4: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && beat_pos == BEAT_LAST) |-> m_tlast);

    assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser)));

    assert_tuser_first_beat_R5: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tuser) |-> (beat_pos == '0));

    assert_done_after_tlast_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(m_tvalid && m_tready && m_tlast));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_len_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err);

endmodule

bind vdec_packetizer vdec_packetizer_chk #(.DW(DW), .OUT_W(OUT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .m_tdata    (m_tdata),
    .m_tvalid   (m_tvalid),
    .m_tready   (m_tready),
    .m_tlast    (m_tlast),
    .m_tuser    (m_tuser),
    .frame_done (frame_done),
    .overflow   (overflow),
    .len_err    (len_err)
);

// File: tb/vdec_packetizer_tb_top.sv
module vdec_packetizer_tb_top;

    localparam int CW    = 8;
    localparam int ACT_W = 8;
    localparam int ACT_H = 6;
    localparam int DW    = 2 * CW;
    localparam int OUT_W = ACT_W / 2;
    localparam int OUT_H = ACT_H / 2;
    localparam int OLW   = $clog2(OUT_H + 1);
    localparam logic [DW-1:0] BLANK = 16'h1080;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [DW-1:0]  vid_word = BLANK;
    logic [DW-1:0]  m_tdata;
    logic           m_tvalid;
    logic           m_tready = 1'b0;
    logic           m_tlast;
    logic           m_tuser;
    logic           frame_done;
    logic [OLW-1:0] out_lines;
    logic           overflow;
    logic           len_err;

    always #4 clk = ~clk;   // 125 MHz

    vdec_packetizer #(.CW(CW), .ACT_W(ACT_W), .ACT_H(ACT_H)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .vid_word   (vid_word),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tlast    (m_tlast),
        .m_tuser    (m_tuser),
        .frame_done (frame_done),
        .out_lines  (out_lines),
        .overflow   (overflow),
        .len_err    (len_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int done_pulses = 0;
    int rdy_mode = 0;           // 0 always ready, 1 pseudo-random, 2 never
    bit finished = 0;
    logic [7:0] lfsr = 8'h5A;

    logic [DW+1:0] exp_q[$];    // {tuser, tlast, data}
    logic [DW+1:0] got_q[$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ready generation and beat capture, away from the rising edge
    always @(negedge clk) begin
        case (rdy_mode)
            0: m_tready = 1'b1;
            1: begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                m_tready = lfsr[0];
            end
            default: m_tready = 1'b0;
        endcase
        if (!rst && m_tvalid && m_tready) got_q.push_back({m_tuser, m_tlast, m_tdata});
        if (!rst && frame_done) done_pulses++;
    end

    function automatic logic [DW-1:0] pix(input int l, input int i, input int fr);
        return {8'(32 + l * 8 + i), 8'(64 + fr)};
    endfunction

    task automatic put(input logic [DW-1:0] w);
        @(negedge clk);
        vid_word = w;
    endtask

    task automatic send_code(input bit v, input bit h);
        logic [7:0] code;
        code = {1'b1, 1'b0, v, h, 4'b0000};
        put(16'hFFFF);
        put(16'h0000);
        put(16'h0000);
        put({code, code});
    endtask

    task automatic send_line(input bit v, input int l, input int nwords, input int fr);
        send_code(v, 1'b0);
        for (int i = 0; i < nwords; i++) put(v ? BLANK : pix(l, i, fr));
        send_code(v, 1'b1);
        for (int i = 0; i < 6; i++) put(BLANK);
    endtask

    task automatic send_vblank(input int n);
        for (int i = 0; i < n; i++) send_line(1'b1, 0, ACT_W, 0);
    endtask

    // expected beats of one output line, per R2 R4 R5
    task automatic exp_line(input int l, input int fr, input bit sof);
        for (int k = 0; k < OUT_W; k++) begin
            int src;
            src = (k / 2) * 4 + (k % 2);
            exp_q.push_back({sof && (k == 0), k == OUT_W - 1, pix(l, src, fr)});
        end
    endtask

    task automatic compare_out(input string tag);
        int n;
        check(got_q.size() == exp_q.size(), {tag, " R1 R3 beat count"}, got_q.size(), exp_q.size());
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++) begin
            check(got_q[i][DW-1:0] == exp_q[i][DW-1:0], {tag, " R2 data"}, got_q[i][DW-1:0], exp_q[i][DW-1:0]);
            check(got_q[i][DW] == exp_q[i][DW], {tag, " R4 tlast"}, got_q[i][DW], exp_q[i][DW]);
            check(got_q[i][DW+1] == exp_q[i][DW+1], {tag, " R5 tuser"}, got_q[i][DW+1], exp_q[i][DW+1]);
        end
        got_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(m_tvalid == 1'b0, "R10 tvalid", m_tvalid, 0);
        check(frame_done == 1'b0, "R10 frame_done", frame_done, 0);
        check(overflow == 1'b0, "R10 overflow", overflow, 0);
        check(len_err == 1'b0, "R10 len_err", len_err, 0);
        check(out_lines == '0, "R10 out_lines", out_lines, 0);

        send_vblank(2);
        check(got_q.size() == 0, "R1 no output in blanking", got_q.size(), 0);

        // frame 0: always ready
        rdy_mode = 0;
        for (int l = 0; l < ACT_H; l++) begin
            send_line(1'b0, l, ACT_W, 0);
            if (l % 2 == 0) exp_line(l, 0, l == 0);
            if (l == 3) check(out_lines == 2, "R6 out_lines mid frame", out_lines, 2);
        end
        send_vblank(2);
        compare_out("frame0");
        check(done_pulses == 1, "R6 frame_done count", done_pulses, 1);
        check(out_lines == '0, "R6 out_lines wrap", out_lines, 0);
        check(len_err == 1'b0, "R9 no false len_err", len_err, 0);

        // frame 1: pseudo-random backpressure
        rdy_mode = 1;
        for (int l = 0; l < ACT_H; l++) begin
            send_line(1'b0, l, ACT_W, 1);
            if (l % 2 == 0) exp_line(l, 1, l == 0);
        end
        send_vblank(2);
        rdy_mode = 0;
        send_vblank(1);
        compare_out("frame1 R7 backpressure");
        check(done_pulses == 2, "R7 R6 frame_done count", done_pulses, 2);
        check(overflow == 1'b0, "R7 no overflow", overflow, 0);

        // frame 2: kept line 2 is one word short
        for (int l = 0; l < ACT_H; l++) begin
            send_line(1'b0, l, (l == 2) ? ACT_W - 1 : ACT_W, 2);
            if (l == 0 || l == 4) exp_line(l, 2, l == 0);
        end
        send_vblank(2);
        compare_out("frame2 R9 short line");
        check(len_err == 1'b1, "R9 len_err set", len_err, 1);
        check(done_pulses == 2, "R9 no frame_done", done_pulses, 2);
        check(out_lines == 2, "R9 out_lines", out_lines, 2);

        // frame 3: unkept line 3 is one word long; counter must restart
        for (int l = 0; l < ACT_H; l++) begin
            send_line(1'b0, l, (l == 3) ? ACT_W + 1 : ACT_W, 3);
            if (l % 2 == 0) exp_line(l, 3, l == 0);
        end
        send_vblank(2);
        compare_out("frame3 R5 restart");
        check(done_pulses == 3, "R6 R5 frame_done after restart", done_pulses, 3);
        check(out_lines == '0, "R6 out_lines after restart", out_lines, 0);
        check(len_err == 1'b1, "R9 len_err sticky", len_err, 1);
        check(overflow == 1'b0, "R8 overflow clear before stall", overflow, 0);

        // frame 4: consumer stalled for a whole frame
        rdy_mode = 2;
        for (int l = 0; l < ACT_H; l++) begin
            send_line(1'b0, l, ACT_W, 4);
            if (l == 0 || l == 2) exp_line(l, 4, l == 0);
        end
        send_vblank(1);
        check(overflow == 1'b1, "R8 overflow set", overflow, 1);
        check(m_tvalid == 1'b1, "R7 tvalid held", m_tvalid, 1);
        rdy_mode = 0;
        send_vblank(2);
        compare_out("frame4 R8 overflow drop");
        check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
        check(done_pulses == 3, "R8 no frame_done", done_pulses, 3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule